// File: doc/BRIEF.md
# Cascaded LED Pixel Node

This block is the data path of one pixel in a chain of single-wire LED drivers. The serial input carries pulse-coded bits. Every bit is a high phase followed by a low phase, and the width of the high phase gives the bit value. The node recovers each bit from that width. It keeps the first 24 bits that arrive after a latch interval as its own colour word. It then regenerates every later bit on its output line, so the next pixel in the chain receives freshly timed pulses.

A low level held for the latch interval ends a frame. On that event a complete captured word moves into the displayed-colour registers, and the node re-arms to take a new word. An incomplete word is dropped. The input passes through a two-stage synchroniser before edges are detected. All timings are parameters counted in clock cycles.

Top module: `pixel_node`

## Requirements
- R1: After reset, `dout_o` is low and `grn_o`, `red_o` and `blu_o` are all zero.
- R2: A bit is recovered as 1 when its synchronised high phase lasts more than `BIT_THRESH_CYC` clock cycles. A high phase of `BIT_THRESH_CYC` cycles or fewer gives 0.
- R3: The first 24 bits after a latch form the node's word, sent MSB first. Bits 1 to 8 are green, bits 9 to 16 are red, and bits 17 to 24 are blue.
- R4: The displayed colours change only when the input has stayed low for `LATCH_CYC` cycles. Low gaps shorter than that have no effect on the colours or on the capture.
- R5: A latch that arrives with fewer than 24 bits captured discards them, and the displayed colours keep their previous values.
- R6: `dout_o` stays low while the node is still collecting its own 24 bits.
- R7: Every bit after the node's 24th within a frame is forwarded on `dout_o`, in order and with the same value.
- R8: A forwarded pulse is high for exactly `T1H_CYC` cycles for a 1 and `T0H_CYC` cycles for a 0. Each forwarded bit occupies a slot of `TBIT_CYC` cycles.
- R9: After every latch the node captures a fresh word, so consecutive frames each update the colours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 1 | Pulse-coded serial input, asynchronous to the clock |
| dout_o | output | 1 | Regenerated serial output to the next pixel |
| grn_o | output | 8 | Displayed green component |
| red_o | output | 8 | Displayed red component |
| blu_o | output | 8 | Displayed blue component |

## Verification
The assertions take for granted that incoming bits are spaced further apart than one regenerated slot of `TBIT_CYC` cycles. Under that condition a forwarded bit never arrives while the previous one is still being sent. They also take for granted that the latch interval is longer than one slot, so regeneration has finished by the time the node re-arms. The stimulus keeps every input bit period at 14 cycles or more, against a 12-cycle output slot. Its longest low gap inside a frame is 40 cycles, well short of the 60-cycle latch interval it uses. Random frames, random surplus lengths and high phases placed exactly on the threshold stay inside these limits.

// File: rtl/pixel_node_pkg.sv
package pixel_node_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned CH_N  = 3;
  localparam int unsigned WORD_W = CH_W * CH_N;

  // wire order: first component received is green, then red, then blue
  typedef struct packed {
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] blu;
  } pixel_t;
endpackage

// File: rtl/pn_sync_edge.sv
module pn_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/pn_bit_recover.sv
module pn_bit_recover #(
  parameter int unsigned BIT_THRESH_CYC = 150,
  parameter int unsigned LATCH_CYC      = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic latch_o
);
  localparam int unsigned HI_MAX = BIT_THRESH_CYC + 1;
  localparam int unsigned HI_W   = $clog2(HI_MAX + 1);
  localparam int unsigned LO_W   = $clog2(LATCH_CYC + 1);

  logic [HI_W-1:0] hi_cnt_q;
  logic [LO_W-1:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
    end else if (rise_i) begin
      hi_cnt_q <= HI_W'(1);
    end else if (lvl_i && hi_cnt_q != HI_W'(HI_MAX)) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
    end else if (lvl_i) begin
      lo_cnt_q <= '0;
    end else if (lo_cnt_q != LO_W'(LATCH_CYC)) begin
      lo_cnt_q <= lo_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
      latch_o   <= 1'b0;
    end else begin
      bit_vld_o <= fall_i;
      bit_o     <= fall_i && (hi_cnt_q > HI_W'(BIT_THRESH_CYC));
      latch_o   <= !lvl_i && (lo_cnt_q == LO_W'(LATCH_CYC - 1));
    end
  end
endmodule

// File: rtl/pn_word_capture.sv
module pn_word_capture
  import pixel_node_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_vld_i,
  input  logic   bit_i,
  input  logic   latch_i,
  output logic   fwd_vld_o,
  output logic   fwd_bit_o,
  output logic   full_o,
  output logic [$clog2(WORD_W+1)-1:0] cnt_o,
  output pixel_t disp_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shr_q;
  pixel_t            disp_q;

  assign full_o = (cnt_q == CNT_W'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      shr_q  <= '0;
      disp_q <= '0;
    end else if (latch_i) begin
      if (full_o) disp_q <= pixel_t'(shr_q);
      cnt_q <= '0;
      shr_q <= '0;
    end else if (bit_vld_i && !full_o) begin
      shr_q <= {shr_q[WORD_W-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fwd_vld_o = bit_vld_i && full_o && !latch_i;
  assign fwd_bit_o = bit_i;
  assign cnt_o     = cnt_q;
  assign disp_o    = disp_q;
endmodule

// File: rtl/pn_bit_regen.sv
module pn_bit_regen #(
  parameter int unsigned T0H_CYC  = 100,
  parameter int unsigned T1H_CYC  = 200,
  parameter int unsigned TBIT_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  output logic busy_o,
  output logic dout_o
);
  localparam int unsigned SLOT_W = $clog2(TBIT_CYC + 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] hi_len_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      slot_q   <= '0;
      hi_len_q <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      slot_q   <= '0;
      hi_len_q <= bit_i ? SLOT_W'(T1H_CYC) : SLOT_W'(T0H_CYC);
    end else if (busy_q) begin
      slot_q <= slot_q + 1'b1;
      if (slot_q == SLOT_W'(TBIT_CYC - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign dout_o = busy_q && (slot_q < hi_len_q);
endmodule

// File: rtl/pixel_node.sv
module pixel_node
  import pixel_node_pkg::*;
#(
  parameter int unsigned BIT_THRESH_CYC = 150,
  parameter int unsigned LATCH_CYC      = 12500,
  parameter int unsigned T0H_CYC        = 100,
  parameter int unsigned T1H_CYC        = 200,
  parameter int unsigned TBIT_CYC       = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            din_i,
  output logic            dout_o,
  output logic [CH_W-1:0] grn_o,
  output logic [CH_W-1:0] red_o,
  output logic [CH_W-1:0] blu_o
);
  logic   lvl_w, rise_w, fall_w;
  logic   bit_vld_w, bit_w, latch_w;
  logic   fwd_vld_w, fwd_bit_w, full_w, busy_w;
  logic [$clog2(WORD_W+1)-1:0] cap_cnt_w;
  pixel_t disp_w;

  pn_sync_edge u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (din_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  pn_bit_recover #(
    .BIT_THRESH_CYC (BIT_THRESH_CYC),
    .LATCH_CYC      (LATCH_CYC)
  ) u_rec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .bit_vld_o (bit_vld_w),
    .bit_o     (bit_w),
    .latch_o   (latch_w)
  );

  pn_word_capture u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_w),
    .bit_i     (bit_w),
    .latch_i   (latch_w),
    .fwd_vld_o (fwd_vld_w),
    .fwd_bit_o (fwd_bit_w),
    .full_o    (full_w),
    .cnt_o     (cap_cnt_w),
    .disp_o    (disp_w)
  );

  pn_bit_regen #(
    .T0H_CYC  (T0H_CYC),
    .T1H_CYC  (T1H_CYC),
    .TBIT_CYC (TBIT_CYC)
  ) u_regen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fwd_vld_w),
    .bit_i   (fwd_bit_w),
    .busy_o  (busy_w),
    .dout_o  (dout_o)
  );

  assign grn_o = disp_w.grn;
  assign red_o = disp_w.red;
  assign blu_o = disp_w.blu;
endmodule

// File: rtl/pixel_node_chk.sv
module pixel_node_chk #(
  parameter int unsigned T0H_CYC = 100,
  parameter int unsigned T1H_CYC = 200
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dout_o,
  input logic [7:0]  grn_o,
  input logic [7:0]  red_o,
  input logic [7:0]  blu_o,
  input logic        latch_w,
  input logic        full_w,
  input logic [4:0]  cap_cnt_w,
  input logic        fwd_vld_w,
  input logic        busy_w
);
  localparam int unsigned HW_MAX = T1H_CYC + 1;
  localparam int unsigned HW_W   = $clog2(HW_MAX + 1);

  logic [HW_W-1:0] hw_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  hw_q <= '0;
    else if (!dout_o)                             hw_q <= '0;
    else if (hw_q != HW_W'(HW_MAX))               hw_q <= hw_q + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!dout_o && grn_o == 8'd0 && red_o == 8'd0 && blu_o == 8'd0));

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_cnt_w <= 5'd24);

  a_r4_hold_without_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_w |=> ($stable(grn_o) && $stable(red_o) && $stable(blu_o)));

  a_r5_partial_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_w && !full_w) |=> ($stable(grn_o) && $stable(red_o) && $stable(blu_o)));

  a_r6_quiet_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_w && !busy_w) |-> !dout_o);

  a_r7_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_w |-> !busy_w);

  a_r8_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dout_o) |-> (hw_q == HW_W'(T0H_CYC) || hw_q == HW_W'(T1H_CYC)));
endmodule

bind pixel_node pixel_node_chk #(
  .T0H_CYC (T0H_CYC),
  .T1H_CYC (T1H_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dout_o    (dout_o),
  .grn_o     (grn_o),
  .red_o     (red_o),
  .blu_o     (blu_o),
  .latch_w   (latch_w),
  .full_w    (full_w),
  .cap_cnt_w (cap_cnt_w),
  .fwd_vld_w (fwd_vld_w),
  .busy_w    (busy_w)
);

// File: tb/pixel_node_tb.sv
module pixel_node_tb;
  localparam int THR  = 5;
  localparam int LAT  = 60;
  localparam int T0H  = 3;
  localparam int T1H  = 8;
  localparam int TBIT = 12;
  localparam int H0   = 3;
  localparam int H1   = 8;
  localparam int LOW  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic [7:0] grn, red, blu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit mon_bits [0:255];
  int mon_n = 0;
  int hi_w = 0;

  always #2 clk = ~clk;

  pixel_node #(
    .BIT_THRESH_CYC (THR),
    .LATCH_CYC      (LAT),
    .T0H_CYC        (T0H),
    .T1H_CYC        (T1H),
    .TBIT_CYC       (TBIT)
  ) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .din_i  (din),
    .dout_o (dout),
    .grn_o  (grn),
    .red_o  (red),
    .blu_o  (blu)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output monitor: decode regenerated pulses, check their width (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (dout) hi_w++;
      else if (hi_w > 0) begin
        n_chk++;
        if (hi_w != T0H && hi_w != T1H) begin
          n_bad++;
          $display("FAIL R8: actual=%0d expected=%0d or %0d", hi_w, T0H, T1H);
        end
        if (mon_n < 256) mon_bits[mon_n] = (hi_w == T1H);
        mon_n++;
        hi_w = 0;
      end
    end
  end

  task automatic send_raw(input int h, input int l);
    din = 1'b1;
    repeat (h) @(negedge clk);
    din = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    send_raw(b ? H1 : H0, LOW);
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_latch();
    din = 1'b0;
    repeat (LAT + 12) @(negedge clk);
  endtask

  function automatic logic [23:0] colours_of(input logic [23:0] w);
    return w; // first byte green, then red, then blue
  endfunction

  task automatic check_colours(input string req, input logic [23:0] exp);
    logic [23:0] e;
    e = colours_of(exp);
    check(req, {8'd0, grn, red, blu}, {8'd0, e});
  endtask

  task automatic frame(input logic [23:0] w, input int nsur, input logic [23:0] prev);
    logic [63:0] sur;
    int base;
    sur = {$urandom, $urandom};
    base = mon_n;
    send_word(w);
    check("R6 quiet while capturing", 32'(mon_n - base), 32'd0);
    check_colours("R4 hold before latch", prev);
    for (int i = 0; i < nsur; i++) send_bit(sur[i]);
    send_latch();
    check_colours("R3/R9 captured word", w);
    check("R7 forwarded count", 32'(mon_n - base), 32'(nsur));
    for (int i = 0; i < nsur; i++)
      check("R7 forwarded value", 32'(mon_bits[base + i]), 32'(sur[i]));
  endtask

  initial begin
    logic [23:0] cur, w;
    int nsur;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dout", 32'(dout), 32'd0);
    check_colours("R1 colours", 24'h0);
    rst_n = 1'b1;
    repeat (LAT + 12) @(negedge clk);
    check_colours("R1 after idle", 24'h0);
    cur = 24'h0;

    // plain frame, no surplus
    w = 24'hA5_3C_0F;
    frame(w, 0, cur);
    cur = w;

    // frame with surplus bits
    w = 24'h12_34_56;
    frame(w, 16, cur);
    cur = w;

    // R5 partial word dropped
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    send_latch();
    check_colours("R5 partial dropped", cur);

    // R2 threshold boundary and R4 short low gaps
    w = 24'h0;
    for (int i = 23; i >= 0; i--) begin
      bit b;
      b = (i % 3) == 0;
      w[i] = b;
      if (i == 12) send_raw(b ? THR + 1 : THR, 40);
      else send_raw(b ? THR + 1 : THR, LOW);
    end
    send_latch();
    check_colours("R2 threshold boundary", w);
    cur = w;

    // all-ones and all-zeros words
    frame(24'hFF_FF_FF, 3, cur);
    cur = 24'hFF_FF_FF;
    frame(24'h00_00_00, 5, cur);
    cur = 24'h0;

    // random frames
    for (int k = 0; k < 6; k++) begin
      w = 24'($urandom);
      nsur = int'($urandom_range(0, 40));
      frame(w, nsur, cur);
      cur = w;
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule